// File: doc/BRIEF.md
# Credit-Weighted Round-Robin Arbiter

This block shares one resource among N requesters and gives at most one grant per cycle. A rotating one-hot token picks the winner among eligible requesters. Each requester also holds a credit count that is loaded from its programmed weight, so service over a long run splits in proportion to the weights.

Each grant uses up one credit of the winner. A requester with no credit left is skipped while any other requester still has credit. Once every requester with work to do is out of credit, or every count is zero, the whole bank reloads from the weights. During that reload cycle no grant is issued.

Weights are 9-bit values. They are written one requester at a time through a small configuration port. A write loads both the weight and that requester's credit count. A weight of zero shuts the requester out completely. The grant vector is registered. It shows the result one clock after the request vector is sampled.

Top module: `cwrr_arbiter`

## Requirements
- R1: The grant `gnt` is registered and is all-zero or one-hot. It reflects the `req` sampled at the previous rising edge.
- R2: A grant bit is set only if the same bit of `req` was set at the sampling edge.
- R3: The search for a winner starts at the token holder and moves to higher indices, wrapping from N-1 to 0. After a grant, the token moves to the index just above the winner (N-1 wraps to 0). Every eligible requester is therefore served within N grants.
- R4: Each grant lowers the winner's credit by one. A requester whose credit is zero is not granted while any requester with credit is requesting.
- R5: Suppose no requester with credit is requesting, and either some requester with a nonzero weight is requesting or all credits are zero. Then every credit reloads from its weight, the grant that cycle is all-zero, and the token holds.
- R6: A requester whose weight is zero is never granted. Its request alone never causes a reload.
- R7: Suppose no eligible requester is requesting and no reload condition holds. Then the grant is all-zero and both the token and the credits hold.
- R8: When `cfg_we` is high, input `cfg_idx` receives the weight `cfg_weight`. Its credit is set to the same value at the same edge, and this takes precedence over a reload or a decrement.
- R9: Synchronous active-high reset clears the grant, gives the token to input 0, and sets every weight and credit to 1.
- R10: Suppose the inputs request continuously. Between two reloads, each requester with weight w receives exactly w grants, followed by one empty reload cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request vector, bit i for requester i |
| cfg_we | input | 1 | Weight write strobe |
| cfg_idx | input | $clog2(N) | Requester index for the weight write |
| cfg_weight | input | WW (9) | Weight value to write |
| gnt | output | N | Registered one-hot grant vector |

## Verification
A corrupted credit count first appears as a grant to an input that should have been skipped. It can also appear as a reload bubble arriving too early or too late. Either shows within one reload period, that is, within the sum of the weights plus one cycle. A misplaced token shows on the very next grant, because the winner differs from the input just above the previous winner. Stuck reload logic shows as a stream of all-zero grants while weighted requests are pending.

// File: rtl/cwrr_pkg.sv
package cwrr_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_GRANT  = 2'd1,
    ACT_RELOAD = 2'd2
  } cwrr_act_e;

  localparam int unsigned CWRR_DEF_WEIGHT = 1;
endpackage

// File: rtl/cwrr_rr_pick.sv
module cwrr_rr_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] elig,
  input  logic [N-1:0] token,
  output logic [N-1:0] pick
);
  localparam int W2 = 2 * N;

  logic [N-1:0]  at_or_above;
  logic [W2-1:0] masked;
  logic [W2-1:0] lowest;

  // ones from the token position upward (token is one-hot)
  assign at_or_above = ~(token - {{(N-1){1'b0}}, 1'b1});
  // upper copy handles wraparound below the token
  assign masked = {elig, elig & at_or_above};
  assign lowest = masked & (~masked + {{(W2-1){1'b0}}, 1'b1});
  assign pick   = lowest[N-1:0] | lowest[W2-1:N];
endmodule

// File: rtl/cwrr_credit_bank.sv
module cwrr_credit_bank #(
  parameter int N     = 4,
  parameter int WW    = 9,
  parameter int DEF_W = 1,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [WW-1:0] cfg_weight,
  input  logic [N-1:0]  dec,
  input  logic          reload,
  output logic [N-1:0]  credit_nz,
  output logic [N-1:0]  weight_nz
);
  generate
    for (genvar g = 0; g < N; g++) begin : g_slot
      logic [WW-1:0] wt_q;
      logic [WW-1:0] cr_q;
      logic          sel;

      assign sel = cfg_we && (cfg_idx == IW'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          wt_q <= WW'(DEF_W);
          cr_q <= WW'(DEF_W);
        end else if (sel) begin
          wt_q <= cfg_weight;
          cr_q <= cfg_weight;
        end else if (reload) begin
          cr_q <= wt_q;
        end else if (dec[g]) begin
          cr_q <= cr_q - {{(WW-1){1'b0}}, 1'b1};
        end
      end

      assign credit_nz[g] = |cr_q;
      assign weight_nz[g] = |wt_q;
    end
  endgenerate
endmodule

// File: rtl/cwrr_arbiter.sv
module cwrr_arbiter #(
  parameter int N     = 4,
  parameter int WW    = 9,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [WW-1:0] cfg_weight,
  output logic [N-1:0]  gnt
);
  import cwrr_pkg::*;

  logic [N-1:0] credit_nz;
  logic [N-1:0] weight_nz;
  logic [N-1:0] eligible;
  logic [N-1:0] pick;
  logic [N-1:0] dec;
  logic [N-1:0] tok_q;
  logic [N-1:0] gnt_q;
  logic         reload;
  cwrr_act_e    act;

  assign eligible = req & credit_nz;

  always_comb begin
    if (|eligible)
      act = ACT_GRANT;
    else if ((|(req & weight_nz)) || !(|credit_nz))
      act = ACT_RELOAD;
    else
      act = ACT_IDLE;
  end

  assign reload = (act == ACT_RELOAD);
  assign dec    = (act == ACT_GRANT) ? pick : '0;

  cwrr_rr_pick #(.N(N)) u_pick (
    .elig  (eligible),
    .token (tok_q),
    .pick  (pick)
  );

  cwrr_credit_bank #(.N(N), .WW(WW), .DEF_W(CWRR_DEF_WEIGHT)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_idx    (cfg_idx),
    .cfg_weight (cfg_weight),
    .dec        (dec),
    .reload     (reload),
    .credit_nz  (credit_nz),
    .weight_nz  (weight_nz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q <= '0;
      tok_q <= {{(N-1){1'b0}}, 1'b1};
    end else begin
      gnt_q <= dec;
      if (act == ACT_GRANT)
        tok_q <= {pick[N-2:0], pick[N-1]};
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/cwrr_checker.sv
module cwrr_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] req,
  input logic [N-1:0] gnt,
  input logic [N-1:0] tok,
  input logic [N-1:0] weight_nz
);
  // R1: grant never has more than one bit set
  a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R2: grant only to an input that requested at the sampling edge
  a_r2_gnt_requested: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> ((gnt & $past(req)) == gnt));

  // R3: token always one-hot and sits just above the last winner
  a_r3_token_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(tok));

  a_r3_token_follows: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> (tok == {gnt[N-2:0], gnt[N-1]}));

  // R6: a zero weight input is never granted
  a_r6_zero_weight_idle: assert property (@(posedge clk) disable iff (rst)
    (|gnt) |-> ((gnt & ~$past(weight_nz)) == '0));

  // R7: an empty grant cycle leaves the token unchanged
  a_r7_token_holds: assert property (@(posedge clk) disable iff (rst)
    (gnt == '0) |-> $stable(tok));
endmodule

bind cwrr_arbiter cwrr_checker #(.N(N)) u_cwrr_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .gnt       (gnt),
  .tok       (tok_q),
  .weight_nz (weight_nz)
);

// File: tb/test_cwrr_arbiter.sv
module test_cwrr_arbiter;
  localparam int N  = 4;
  localparam int WW = 9;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [WW-1:0] cfg_weight = '0;
  logic [N-1:0]  gnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cwrr_arbiter #(.N(N), .WW(WW)) i_cwrr_arbiter (
    .clk(clk), .rst(rst), .req(req), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_weight(cfg_weight), .gnt(gnt)
  );

  // {req, expected grant}; weights 2,1,1,0 loaded, token at input 0
  localparam logic [7:0] VEC [0:12] = '{
    {4'b1111, 4'b0001}, {4'b1111, 4'b0010}, {4'b1111, 4'b0100},
    {4'b1111, 4'b0001}, {4'b1111, 4'b0000}, {4'b1111, 4'b0010},
    {4'b0001, 4'b0001}, {4'b0000, 4'b0000}, {4'b0100, 4'b0100},
    {4'b0010, 4'b0000}, {4'b0010, 4'b0010}, {4'b1000, 4'b0000},
    {4'b1011, 4'b0001}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] r);
    req = r;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int idx, input int w);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_weight = WW'(w);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c0, c1, cz;
    repeat (3) @(posedge clk);
    #1;
    chk(gnt, 4'b0000, "R9 reset grant");
    rst = 1'b0;

    // R9 defaults: weight 1 each, token at 0; R5 reload bubble
    step(4'b1111); chk(gnt, 4'b0001, "R9 first default grant");
    step(4'b1111); chk(gnt, 4'b0010, "R3 rotate to 1");
    step(4'b1111); chk(gnt, 4'b0100, "R3 rotate to 2");
    step(4'b1111); chk(gnt, 4'b1000, "R3 rotate to 3");
    step(4'b1111); chk(gnt, 4'b0000, "R5 all credits spent");
    step(4'b0000);

    // R8: writes load weight and credit
    wr(0, 2); wr(1, 1); wr(2, 1); wr(3, 0);
    for (int i = 0; i < 13; i++) begin
      step(VEC[i][7:4]);
      chk(gnt, {28'b0, VEC[i][3:0]}, $sformatf("R3 R4 R5 R6 R7 R8 vector %0d", i));
    end

    // R10: weights 4 and 2, continuous requests, token starts at 1
    step(4'b0000);
    wr(0, 4); wr(1, 2); wr(2, 0); wr(3, 0);
    c0 = 0; c1 = 0; cz = 0;
    for (int i = 0; i < 14; i++) begin
      step(4'b0011);
      if (gnt == 4'b0001) c0++;
      else if (gnt == 4'b0010) c1++;
      else if (gnt == 4'b0000) cz++;
      chk($countones(gnt) <= 1, 1, "R1 one-hot under load");
    end
    chk(c0, 8, "R10 grants to input 0");
    chk(c1, 4, "R10 grants to input 1");
    chk(cz, 2, "R10 reload bubbles");

    // R9: reset in mid-run restores defaults
    req = 4'b1111;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(gnt, 4'b0000, "R9 grant cleared by reset");
    rst = 1'b0;
    step(4'b1111); chk(gnt, 4'b0001, "R9 token back at 0");
    step(4'b1111); chk(gnt, 4'b0010, "R9 default weight 1");

    // R6: all weights zero, no grant at all
    step(4'b0000);
    wr(0, 0); wr(1, 0); wr(2, 0); wr(3, 0);
    for (int i = 0; i < 3; i++) begin
      step(4'b1111);
      chk(gnt, 4'b0000, "R6 zero weights excluded");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule